// File: doc/BRIEF.md
# Power Delivery Transmit Arbiter with Acknowledge Retry

This block decides what the protocol layer of a USB Power Delivery port sends next and follows each transmission to its end. Three sources compete for the PHY transmitter: messages handed down by the upper protocol layer, GoodCRC acknowledgements that the local receive path asks for, and hard-reset requests. The block picks one source, pulses a start strobe towards the PHY together with a kind code, and then tracks the PHY's completion events.

An upper-layer message counts as delivered only when the partner answers with a GoodCRC that carries the same 3-bit message ID. A PHY failure, a GoodCRC with the wrong ID, or a silent partner until the acknowledge timer runs out all lead to a retransmission, up to a bounded retry count. When retries run out, the upper layer gets a single failure pulse. GoodCRC replies are fire-and-forget. A hard reset takes over from whatever is going on.

Top module: `pd_tx_arbiter`

## Requirements
- R1: During and after reset all outputs are low and the block is idle, so a request arriving first after reset is started one cycle later.
- R2: When a GoodCRC request and an upper-layer request are both pending in idle, the GoodCRC reply is started first and the upper-layer request stays pending.
- R3: Each transmission attempt is one cycle of `start_o`, registered one clock after the decision, with `start_kind_o` = 0 for an upper-layer message, 1 for a GoodCRC reply and 2 for a hard reset.
- R4: After `phy_sent_i` for an upper-layer message, a GoodCRC whose ID equals the message ID that `msg_id_i` (header bits 11:9) carried at request time gives a one-cycle `done_ok_o` and a return to idle.
- R5: A `phy_fail_i` during an upper-layer attempt restarts the message at once while fewer than RETRY_MAX retries have been used. Otherwise it gives a one-cycle `done_fail_o`. RETRY_MAX is 2 when PD_REV3 is 1 and 3 otherwise.
- R6: A GoodCRC with a non-matching ID while the block is waiting for an acknowledgement causes a retransmission, or a failure report when retries are used up.
- R7: If no GoodCRC arrives, the retransmission starts exactly T cycles after the clock edge that took `phy_sent_i`, with T = CLK_FREQ_HZ·ACK_TIMEOUT_US/10^6. When retries are used up, `done_fail_o` pulses instead.
- R8: A GoodCRC reply ends on either `phy_sent_i` or `phy_fail_i`. It is never retried and never reported.
- R9: `hrst_req_i` in any state starts a hard-reset transmission on the next cycle, even in the middle of another transmission.
- R10: `phy_hr_done_i` or `phy_hr_fail_i` ends the hard reset. All pending requests, including any that arrive in that same cycle, are dropped, so nothing starts afterwards.
- R11: A request still pending when the block returns to idle is started one cycle later, without any new event.
- R12: A received GoodCRC outside the acknowledge-wait state has no effect: there is no report and no retransmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_req_i | input | 1 | Upper-layer message request pulse |
| msg_id_i | input | 3 | Message ID of that request (header bits 11:9), valid with msg_req_i |
| ack_req_i | input | 1 | GoodCRC reply request pulse |
| hrst_req_i | input | 1 | Hard-reset request pulse |
| phy_sent_i | input | 1 | PHY: message transmitted |
| phy_fail_i | input | 1 | PHY: message aborted, discarded or underrun |
| phy_hr_done_i | input | 1 | PHY: hard reset transmitted |
| phy_hr_fail_i | input | 1 | PHY: hard reset discarded |
| rx_ack_i | input | 1 | A GoodCRC was received |
| rx_ack_id_i | input | 3 | Message ID of the received GoodCRC |
| start_o | output | 1 | One-cycle transmit start strobe |
| start_kind_o | output | 2 | What to send: 0 message, 1 GoodCRC, 2 hard reset |
| done_ok_o | output | 1 | Upper-layer message acknowledged (pulse) |
| done_fail_o | output | 1 | Upper-layer message given up (pulse) |

## Verification
The bench targets the exact timeout cycle. A timer that is off by one shows up as a retransmission strobe one cycle early or late. It checks that a wrong-ID GoodCRC is treated as a miss and not as success, and it pushes retries to the last one so that an off-by-one limit gives one attempt too many or too few before the failure pulse. Simultaneous GoodCRC and upper-layer requests expose a swapped priority. A hard reset in the middle of a message, followed by a request during the reset, catches a design that fails to preempt or that keeps stale requests and starts them after the reset.

// File: rtl/pd_tx_pkg.sv
// Shared types for the power-delivery transmit arbiter.
// Assumes: 3-bit message IDs, three transmit kinds.
package pd_tx_pkg;
    localparam int ID_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_SEND_MSG  = 3'd1,
        ST_SEND_ACK  = 3'd2,
        ST_HRST      = 3'd3,
        ST_AWAIT_ACK = 3'd4
    } tx_state_e;

    typedef enum logic [1:0] {
        KIND_MSG  = 2'd0,
        KIND_ACK  = 2'd1,
        KIND_HRST = 2'd2
    } tx_kind_e;
endpackage

// File: rtl/pd_tx_pending.sv
// Holds pending GoodCRC and upper-layer requests plus the ID of the latest
// upper-layer request. The effective outputs include requests that arrive in
// the current cycle, so idle can start them without waiting a cycle.
// Assumes: the clear inputs act only on requests reported as effective.
module pd_tx_pending #(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ack_req_i,
    input  logic            msg_req_i,
    input  logic [ID_W-1:0] msg_id_i,
    input  logic            clr_ack_i,
    input  logic            clr_msg_i,
    input  logic            clr_all_i,
    output logic            eff_ack_o,
    output logic            eff_msg_o,
    output logic [ID_W-1:0] eff_id_o
);
    logic            pend_ack_q;
    logic            pend_msg_q;
    logic [ID_W-1:0] id_q;

    // Merge stored and newly arriving requests.
    always_comb begin
        eff_ack_o = pend_ack_q | ack_req_i;
        eff_msg_o = pend_msg_q | msg_req_i;
        eff_id_o  = msg_req_i ? msg_id_i : id_q;
    end

    // Update pending flags; a global clear wins over everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_ack_q <= 1'b0;
            pend_msg_q <= 1'b0;
        end else if (clr_all_i) begin
            pend_ack_q <= 1'b0;
            pend_msg_q <= 1'b0;
        end else begin
            pend_ack_q <= eff_ack_o & ~clr_ack_i;
            pend_msg_q <= eff_msg_o & ~clr_msg_i;
        end
    end

    // Capture the ID of each new upper-layer request.
    always_ff @(posedge clk) begin
        if (!rst_n)         id_q <= '0;
        else if (msg_req_i) id_q <= msg_id_i;
    end

    // A start may only clear a request that was actually pending.
    assert_clear_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ack_i |-> eff_ack_o) and (clr_msg_i |-> eff_msg_o));
endmodule

// File: rtl/pd_tx_retry.sv
// Counts retransmissions of the current upper-layer message and flags when
// the limit is reached. Assumes: clear and increment are never asserted together.
module pd_tx_retry #(
    parameter int RETRY_MAX = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic exhausted_o
);
    localparam int CNT_W = $clog2(RETRY_MAX + 1);

    logic [CNT_W-1:0] cnt_q;

    // Limit reached flag.
    assign exhausted_o = (cnt_q >= CNT_W'(RETRY_MAX));

    // Retry count register.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (inc_i) cnt_q <= cnt_q + 1'b1;
    end

    assert_no_inc_past_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> !exhausted_o);
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(RETRY_MAX));
endmodule

// File: rtl/pd_tx_ack_timer.sv
// Acknowledge-wait timer. Counts cycles while run_i is high and flags expiry
// in the cycle the TMO_CYC-th edge will be taken; cleared whenever not running.
// Assumes: TMO_CYC >= 1 and the caller leaves the wait state on expiry.
module pd_tx_ack_timer #(
    parameter int unsigned TMO_CYC = 16000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(TMO_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    // Expiry when the last cycle of the window is reached.
    assign expired_o = run_i && (cnt_q == CNT_W'(TMO_CYC - 1));

    // Cycle counter, stopped and cleared outside the wait state.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (run_i && !expired_o)  cnt_q <= cnt_q + 1'b1;
        else                           cnt_q <= '0;
    end
endmodule

// File: rtl/pd_tx_fsm.sv
// Transmit state machine: chooses the source, issues start strobes, handles
// PHY completion, acknowledge matching, retry and reporting. All outputs to
// the block's edge are registered.
// Assumes: hard reset requests have top priority over every other input.
module pd_tx_fsm
    import pd_tx_pkg::*;
#(
    parameter int IDW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hrst_req_i,
    input  logic           eff_ack_i,
    input  logic           eff_msg_i,
    input  logic [IDW-1:0] eff_id_i,
    input  logic           phy_sent_i,
    input  logic           phy_fail_i,
    input  logic           phy_hr_done_i,
    input  logic           phy_hr_fail_i,
    input  logic           rx_ack_i,
    input  logic [IDW-1:0] rx_ack_id_i,
    input  logic           retry_exh_i,
    input  logic           timeout_i,
    output logic           timer_run_o,
    output logic           clr_ack_o,
    output logic           clr_msg_o,
    output logic           clr_all_o,
    output logic           retry_clr_o,
    output logic           retry_inc_o,
    output logic           start_o,
    output logic [1:0]     start_kind_o,
    output logic           done_ok_o,
    output logic           done_fail_o
);
    tx_state_e      st_q, st_d;
    logic [IDW-1:0] id_q;
    logic           id_load;
    logic           start_d, ok_d, fail_d;
    tx_kind_e       kind_d, kind_q;
    logic           ack_match;

    assign timer_run_o  = (st_q == ST_AWAIT_ACK);
    assign ack_match    = rx_ack_i && (rx_ack_id_i == id_q);
    assign start_kind_o = kind_q;

    // Next-state and action decode.
    always_comb begin
        st_d        = st_q;
        start_d     = 1'b0;
        kind_d      = KIND_MSG;
        ok_d        = 1'b0;
        fail_d      = 1'b0;
        clr_ack_o   = 1'b0;
        clr_msg_o   = 1'b0;
        clr_all_o   = 1'b0;
        retry_clr_o = 1'b0;
        retry_inc_o = 1'b0;
        id_load     = 1'b0;
        if (hrst_req_i) begin
            st_d    = ST_HRST;
            start_d = 1'b1;
            kind_d  = KIND_HRST;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (eff_ack_i) begin
                        st_d        = ST_SEND_ACK;
                        start_d     = 1'b1;
                        kind_d      = KIND_ACK;
                        clr_ack_o   = 1'b1;
                        retry_clr_o = 1'b1;
                    end else if (eff_msg_i) begin
                        st_d        = ST_SEND_MSG;
                        start_d     = 1'b1;
                        kind_d      = KIND_MSG;
                        clr_msg_o   = 1'b1;
                        retry_clr_o = 1'b1;
                        id_load     = 1'b1;
                    end
                end
                ST_SEND_MSG: begin
                    if (phy_sent_i) begin
                        st_d = ST_AWAIT_ACK;
                    end else if (phy_fail_i) begin
                        if (!retry_exh_i) begin
                            start_d     = 1'b1;
                            retry_inc_o = 1'b1;
                        end else begin
                            st_d   = ST_IDLE;
                            fail_d = 1'b1;
                        end
                    end
                end
                ST_SEND_ACK: begin
                    if (phy_sent_i || phy_fail_i) st_d = ST_IDLE;
                end
                ST_AWAIT_ACK: begin
                    if (ack_match) begin
                        st_d = ST_IDLE;
                        ok_d = 1'b1;
                    end else if (rx_ack_i || timeout_i) begin
                        if (!retry_exh_i) begin
                            st_d        = ST_SEND_MSG;
                            start_d     = 1'b1;
                            retry_inc_o = 1'b1;
                        end else begin
                            st_d   = ST_IDLE;
                            fail_d = 1'b1;
                        end
                    end
                end
                ST_HRST: begin
                    if (phy_hr_done_i || phy_hr_fail_i) begin
                        st_d        = ST_IDLE;
                        clr_all_o   = 1'b1;
                        retry_clr_o = 1'b1;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State and registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            start_o     <= 1'b0;
            kind_q      <= KIND_MSG;
            done_ok_o   <= 1'b0;
            done_fail_o <= 1'b0;
        end else begin
            st_q        <= st_d;
            start_o     <= start_d;
            kind_q      <= kind_d;
            done_ok_o   <= ok_d;
            done_fail_o <= fail_d;
        end
    end

    // Latch the message ID for acknowledge matching.
    always_ff @(posedge clk) begin
        if (!rst_n)       id_q <= '0;
        else if (id_load) id_q <= eff_id_i;
    end

    assert_single_report_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_ok_o && done_fail_o));
    assert_ok_needs_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok_o |-> $past(rx_ack_i) && ($past(rx_ack_id_i) == $past(id_q)));
    assert_fail_needs_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_fail_o |-> $past(retry_exh_i));
    assert_timeout_in_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_i |-> (st_q == ST_AWAIT_ACK));
endmodule

// File: rtl/pd_tx_arbiter.sv
// Top level of the power-delivery transmit arbiter: request holding, retry
// counting, acknowledge timer and the control state machine.
// Assumes: CLK_FREQ_HZ * ACK_TIMEOUT_US >= 1e6 (at least one timer cycle).
module pd_tx_arbiter
    import pd_tx_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ    = 16_000_000,
    parameter int unsigned ACK_TIMEOUT_US = 1000,
    parameter bit          PD_REV3        = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            msg_req_i,
    input  logic [ID_W-1:0] msg_id_i,
    input  logic            ack_req_i,
    input  logic            hrst_req_i,
    input  logic            phy_sent_i,
    input  logic            phy_fail_i,
    input  logic            phy_hr_done_i,
    input  logic            phy_hr_fail_i,
    input  logic            rx_ack_i,
    input  logic [ID_W-1:0] rx_ack_id_i,
    output logic            start_o,
    output logic [1:0]      start_kind_o,
    output logic            done_ok_o,
    output logic            done_fail_o
);
    localparam longint unsigned TMO_L =
        (longint'(CLK_FREQ_HZ) * longint'(ACK_TIMEOUT_US)) / 64'd1_000_000;
    localparam int unsigned TMO_CYC   = (TMO_L == 0) ? 1 : int'(TMO_L);
    localparam int          RETRY_MAX = PD_REV3 ? 2 : 3;

    logic            eff_ack, eff_msg;
    logic [ID_W-1:0] eff_id;
    logic            clr_ack, clr_msg, clr_all;
    logic            retry_clr, retry_inc, retry_exh;
    logic            timer_run, timeout;

    pd_tx_pending #(.ID_W(ID_W)) u_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_req_i (ack_req_i),
        .msg_req_i (msg_req_i),
        .msg_id_i  (msg_id_i),
        .clr_ack_i (clr_ack),
        .clr_msg_i (clr_msg),
        .clr_all_i (clr_all),
        .eff_ack_o (eff_ack),
        .eff_msg_o (eff_msg),
        .eff_id_o  (eff_id)
    );

    pd_tx_retry #(.RETRY_MAX(RETRY_MAX)) u_retry (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (retry_clr),
        .inc_i       (retry_inc),
        .exhausted_o (retry_exh)
    );

    pd_tx_ack_timer #(.TMO_CYC(TMO_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (timer_run),
        .expired_o (timeout)
    );

    pd_tx_fsm #(.IDW(ID_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .hrst_req_i    (hrst_req_i),
        .eff_ack_i     (eff_ack),
        .eff_msg_i     (eff_msg),
        .eff_id_i      (eff_id),
        .phy_sent_i    (phy_sent_i),
        .phy_fail_i    (phy_fail_i),
        .phy_hr_done_i (phy_hr_done_i),
        .phy_hr_fail_i (phy_hr_fail_i),
        .rx_ack_i      (rx_ack_i),
        .rx_ack_id_i   (rx_ack_id_i),
        .retry_exh_i   (retry_exh),
        .timeout_i     (timeout),
        .timer_run_o   (timer_run),
        .clr_ack_o     (clr_ack),
        .clr_msg_o     (clr_msg),
        .clr_all_o     (clr_all),
        .retry_clr_o   (retry_clr),
        .retry_inc_o   (retry_inc),
        .start_o       (start_o),
        .start_kind_o  (start_kind_o),
        .done_ok_o     (done_ok_o),
        .done_fail_o   (done_fail_o)
    );

    assert_hrst_preempts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hrst_req_i |=> start_o && (start_kind_o == 2'd2));
    assert_kind_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (start_kind_o != 2'd3));
endmodule

// File: tb/tb_pd_tx_arbiter.sv
module tb_pd_tx_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int TB_FREQ    = 20_000;
    localparam int TB_TMO     = 20;   // 20 kHz * 1000 us / 1e6
    localparam int LIM        = 2;    // PD_REV3 = 1

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       msg_req = 0, ack_req = 0, hrst_req = 0;
    logic [2:0] msg_id = 0, rx_id = 0;
    logic       phy_sent = 0, phy_fail = 0, hr_done = 0, hr_fail = 0, rx_ack = 0;
    logic       start_o, done_ok, done_fail;
    logic [1:0] kind_o;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    pd_tx_arbiter #(.CLK_FREQ_HZ(TB_FREQ), .ACK_TIMEOUT_US(1000), .PD_REV3(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .msg_req_i(msg_req), .msg_id_i(msg_id),
        .ack_req_i(ack_req), .hrst_req_i(hrst_req), .phy_sent_i(phy_sent),
        .phy_fail_i(phy_fail), .phy_hr_done_i(hr_done), .phy_hr_fail_i(hr_fail),
        .rx_ack_i(rx_ack), .rx_ack_id_i(rx_id), .start_o(start_o),
        .start_kind_o(kind_o), .done_ok_o(done_ok), .done_fail_o(done_fail));

    // Behavioural reference model: 0 idle, 1 msg, 2 ack, 3 hard reset, 4 wait
    int m_st = 0, m_rt = 0, m_wait = 0, m_id = 0, m_hid = 0, m_kind = 0;
    bit m_pa = 0, m_pu = 0, m_start = 0, m_ok = 0, m_fail = 0;

    always @(posedge clk) begin : model
        bit pa, pu, tmo;
        if (!rst_n) begin
            m_st = 0; m_rt = 0; m_pa = 0; m_pu = 0; m_hid = 0; m_id = 0;
            m_start = 0; m_ok = 0; m_fail = 0; m_kind = 0;
        end else begin
            m_start = 0; m_ok = 0; m_fail = 0; m_kind = 0;
            pa = m_pa || ack_req;
            pu = m_pu || msg_req;
            if (msg_req) m_hid = msg_id;
            if (hrst_req) begin
                m_st = 3; m_start = 1; m_kind = 2;
            end else begin
                case (m_st)
                    0: if (pa) begin
                           pa = 0; m_rt = 0; m_st = 2; m_start = 1; m_kind = 1;
                       end else if (pu) begin
                           pu = 0; m_rt = 0; m_id = m_hid; m_st = 1; m_start = 1;
                       end
                    1: if (phy_sent) begin
                           m_st = 4; m_wait = 0;
                       end else if (phy_fail) begin
                           if (m_rt < LIM) begin m_rt++; m_start = 1; end
                           else begin m_st = 0; m_fail = 1; end
                       end
                    2: if (phy_sent || phy_fail) m_st = 0;
                    4: begin
                           m_wait++;
                           tmo = (m_wait == TB_TMO);
                           if (rx_ack && rx_id == m_id) begin
                               m_ok = 1; m_st = 0;
                           end else if (rx_ack || tmo) begin
                               if (m_rt < LIM) begin m_rt++; m_st = 1; m_start = 1; end
                               else begin m_st = 0; m_fail = 1; end
                           end
                       end
                    3: if (hr_done || hr_fail) begin
                           m_st = 0; pa = 0; pu = 0; m_rt = 0;
                       end
                    default: m_st = 0;
                endcase
            end
            m_pa = pa; m_pu = pu;
        end
    end

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (!finished) begin
            checks++;
            if (start_o !== m_start || done_ok !== m_ok || done_fail !== m_fail ||
                (m_start && kind_o !== 2'(m_kind))) begin
                errors++;
                $display("FAIL model %s: start/kind/ok/fail = %0b/%0d/%0b/%0b expected %0b/%0d/%0b/%0b",
                         tag, start_o, kind_o, done_ok, done_fail, m_start, m_kind, m_ok, m_fail);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance to the next falling edge and drop all single-cycle inputs.
    task automatic step();
        @(negedge clk);
        msg_req = 0; ack_req = 0; hrst_req = 0; phy_sent = 0; phy_fail = 0;
        hr_done = 0; hr_fail = 0; rx_ack = 0;
    endtask

    task automatic expect_start(input int kind, input string req);
        chk(start_o === 1'b1 && kind_o === 2'(kind), req, {start_o, kind_o}, 4 | kind);
    endtask

    task automatic expect_quiet(input string req);
        chk(start_o === 0 && done_ok === 0 && done_fail === 0, req,
            {start_o, done_ok, done_fail}, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        expect_quiet("R1");
        rst_n = 1;
        step();
        expect_quiet("R1");

        // R3 R4: message, sent, matching acknowledgement
        tag = "R4";
        msg_req = 1; msg_id = 3'd5; step();
        expect_start(0, "R3");
        phy_sent = 1; step();
        rx_ack = 1; rx_id = 3'd5; step();
        chk(done_ok === 1, "R4", done_ok, 1);
        step();
        chk(done_ok === 0, "R4", done_ok, 0);

        // R6: wrong ID retries, right ID succeeds
        tag = "R6";
        msg_req = 1; msg_id = 3'd3; step();
        phy_sent = 1; step();
        rx_ack = 1; rx_id = 3'd6; step();
        expect_start(0, "R6");
        chk(done_ok === 0, "R6", done_ok, 0);
        phy_sent = 1; step();
        rx_ack = 1; rx_id = 3'd3; step();
        chk(done_ok === 1, "R6", done_ok, 1);

        // R5: PHY failures retry LIM times then fail
        tag = "R5";
        msg_req = 1; msg_id = 3'd1; step();
        for (int i = 0; i < LIM; i++) begin
            phy_fail = 1; step();
            expect_start(0, "R5");
        end
        phy_fail = 1; step();
        chk(done_fail === 1 && start_o === 0, "R5", {done_fail, start_o}, 2);

        // R7: timeout exactly TB_TMO cycles after sent
        tag = "R7";
        msg_req = 1; msg_id = 3'd2; step();
        for (int r = 0; r <= LIM; r++) begin
            phy_sent = 1; step();
            for (int c = 1; c < TB_TMO; c++) begin
                step();
                chk(start_o === 0 && done_fail === 0, "R7", start_o, 0);
            end
            step();
            if (r < LIM) expect_start(0, "R7");
            else chk(done_fail === 1, "R7", done_fail, 1);
        end

        // R2 R8 R11: simultaneous requests, reply first, message after
        tag = "R2";
        ack_req = 1; msg_req = 1; msg_id = 3'd4; step();
        expect_start(1, "R2");
        tag = "R8";
        phy_fail = 1; step();
        expect_quiet("R8");
        step();
        expect_start(0, "R11");
        phy_sent = 1; step();
        rx_ack = 1; rx_id = 3'd4; step();
        chk(done_ok === 1, "R4", done_ok, 1);
        ack_req = 1; step();
        expect_start(1, "R3");
        phy_sent = 1; step();
        step();
        expect_quiet("R8");

        // R12: acknowledgement outside the wait state
        tag = "R12";
        rx_ack = 1; rx_id = 3'd0; step();
        expect_quiet("R12");
        msg_req = 1; msg_id = 3'd7; step();
        rx_ack = 1; rx_id = 3'd7; step();
        expect_quiet("R12");
        phy_sent = 1; step();
        rx_ack = 1; rx_id = 3'd7; step();
        chk(done_ok === 1, "R4", done_ok, 1);

        // R9 R10: hard reset mid-message, request during reset dropped
        tag = "R9";
        msg_req = 1; msg_id = 3'd2; step();
        hrst_req = 1; step();
        expect_start(2, "R9");
        tag = "R10";
        ack_req = 1; step();
        hr_done = 1; msg_req = 1; step();
        repeat (3) begin
            step();
            expect_quiet("R10");
        end
        hrst_req = 1; step();
        expect_start(2, "R9");
        hr_fail = 1; step();
        step();
        expect_quiet("R10");
        ack_req = 1; step();
        expect_start(1, "R10");
        phy_sent = 1; step();
        repeat (4) step();
        finish_run();
    end
endmodule